// File: doc/BRIEF.md
# Hart Halt-Mode Debug Controller

This block decides when a single hart leaves normal execution for halt-mode debug and when it returns. Four sources can halt the hart: a rising edge on the external halt-request pin, a reset-time halt request that is sampled as reset is released, an ebreak retiring in a privilege level whose ebreak enable is set, and the completion of one instruction while single stepping. On entry the block saves the PC to resume at, the cause and the privilege level, and it redirects fetch to a fixed debug entry address.

While halted, an exception redirects fetch to a separate debug-exception address, and an ebreak sends fetch back to the entry address. Neither changes the saved state. A dret ends debug mode: the block raises a resume request, redirects fetch to the saved PC and presents the privilege level to restore. A small control field holds the three per-privilege ebreak enables and the step bit. Software can write it only while the hart is halted.

All outputs are registered, so every result appears one clock after the stimulus. The entry and exception addresses, the reset PC, the PC width and the presence of supervisor and user modes are parameters. When a mode is absent, its ebreak enable is tied to zero.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls with `resethalt_req` low, `dbg_mode`, `dpc`, `cause`, `cfg_rdata`, `dpc_we`, `redirect_valid` and `resume_req` are all zero.
- R2: A 0-to-1 change of `halt_req` while running enters debug mode one cycle later with `cause`=3, `dpc`=`save_pc`, a one-cycle `dpc_we` and `redirect_valid` pulse and `redirect_pc`=`DBG_ADDR`. A level held high does not re-trigger, and a rising edge while already halted changes nothing.
- R3: If `resethalt_req` is high in the cycle `rst` falls, the hart is in debug mode in the next cycle with `cause`=5, `dpc`=`RESET_PC` and a saved privilege of machine (3). If it is low, the hart runs.
- R4: An ebreak strobe while running enters debug mode with `cause`=1 only when the enable bit for `cur_priv` is set. Privilege encodings are U=0, S=1, M=3, and the enables are `cfg` bit 0 for M, bit 1 for S and bit 2 for U. Otherwise the hart keeps running.
- R5: An exception strobe while halted gives a `redirect_valid` pulse to `DBG_EXC_ADDR` and leaves `dbg_mode`, `dpc` and `cause` unchanged. While running, the exception strobe is ignored.
- R6: A dret while halted clears `dbg_mode`, pulses `resume_req` and `redirect_valid`, and sets `redirect_pc` to `dpc` and `resume_priv` to the privilege saved at entry. A dret while running has no effect.
- R7: If `cfg` bit 3 (step) is set when dret is taken, the first `retire` strobe after resume re-enters debug mode with `cause`=4 and `dpc`=`save_pc`. This repeats after each dret until the bit is cleared.
- R8: When entry sources coincide, the cause is chosen in the order reset-halt (5), halt request (3), step (4), ebreak (1).
- R9: `cfg_we` writes `cfg_wdata` into the control field only while halted, and the new value appears on `cfg_rdata` one cycle later. While running, writes are ignored.
- R10: An ebreak strobe while halted pulses `redirect_valid` to `DBG_ADDR` and leaves `dpc`, `cause` and `dbg_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt request, acts on its rising edge |
| resethalt_req | input | 1 | Level request to halt as reset is released |
| ebreak_ret | input | 1 | Strobe: an ebreak retired |
| dret_ret | input | 1 | Strobe: a dret retired |
| exc_ret | input | 1 | Strobe: an instruction raised an exception |
| retire | input | 1 | Strobe: a normal instruction retired |
| cur_priv | input | 2 | Current privilege level (U=0, S=1, M=3) |
| save_pc | input | XLEN | PC to save if entry happens this cycle |
| cfg_we | input | 1 | Control field write strobe |
| cfg_wdata | input | 4 | {step, ebreak U, ebreak S, ebreak M} |
| cfg_rdata | output | 4 | Current control field |
| dbg_mode | output | 1 | Hart is in debug mode |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | XLEN | Fetch redirect target |
| dpc_we | output | 1 | One-cycle pulse when the saved PC is captured |
| dpc | output | XLEN | Saved resume PC |
| cause | output | 3 | Cause of the latest entry |
| resume_req | output | 1 | One-cycle pulse on leaving debug mode |
| resume_priv | output | 2 | Privilege level to resume in |

## Verification
Every result of this block is due exactly one clock after the edge that samples its stimulus. This holds for entry, exception and ebreak redirects, the dret resume, and a control-field write. The reset-halt result is due one clock after the first edge that sees `rst` low. The bench changes inputs just after a falling edge and checks outputs at the following falling edge, half a period after the capturing rising edge. It drops each strobe only after that check, so one-cycle pulses are caught while they are high and checked again one cycle later to confirm they have cleared.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   typedef enum logic [2:0] {
      CAUSE_NONE      = 3'd0,
      CAUSE_EBREAK    = 3'd1,
      CAUSE_HALT      = 3'd3,
      CAUSE_STEP      = 3'd4,
      CAUSE_RESETHALT = 3'd5
   } cause_e;

   localparam int CFG_W    = 4;
   localparam int CFG_EBM  = 0;
   localparam int CFG_EBS  = 1;
   localparam int CFG_EBU  = 2;
   localparam int CFG_STEP = 3;

   typedef struct packed {
      logic   valid;
      cause_e cause;
   } entry_req_t;

endpackage

// File: rtl/dbg_event_detect.sv
module dbg_event_detect (
   input  logic clk,
   input  logic rst,
   input  logic halt_req,
   input  logic resethalt_req,
   output logic halt_rise,
   output logic resethalt_hit
);
   logic hreq_q;
   logic rst_q;

   always_ff @(posedge clk) begin
      hreq_q <= halt_req;
      rst_q  <= rst;
   end

   assign halt_rise     = halt_req & ~hreq_q & ~rst;
   assign resethalt_hit = rst_q & ~rst & resethalt_req;
endmodule

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
   import dbg_halt_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1,
   parameter bit HAS_UMODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output logic [3:0]       eb_by_priv,
   output logic             step_en
);
   logic ebm_q;
   logic ebs_q;
   logic ebu_q;
   logic step_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ebm_q  <= 1'b0;
         step_q <= 1'b0;
      end else if (wr_en) begin
         ebm_q  <= wdata[CFG_EBM];
         step_q <= wdata[CFG_STEP];
      end
   end

   if (HAS_SMODE) begin : g_smode
      always_ff @(posedge clk) begin
         if (rst)        ebs_q <= 1'b0;
         else if (wr_en) ebs_q <= wdata[CFG_EBS];
      end
   end else begin : g_no_smode
      assign ebs_q = 1'b0;
   end

   if (HAS_UMODE) begin : g_umode
      always_ff @(posedge clk) begin
         if (rst)        ebu_q <= 1'b0;
         else if (wr_en) ebu_q <= wdata[CFG_EBU];
      end
   end else begin : g_no_umode
      assign ebu_q = 1'b0;
   end

   always_comb begin
      rdata           = '0;
      rdata[CFG_EBM]  = ebm_q;
      rdata[CFG_EBS]  = ebs_q;
      rdata[CFG_EBU]  = ebu_q;
      rdata[CFG_STEP] = step_q;
   end

   always_comb begin
      eb_by_priv           = '0;
      eb_by_priv[PRIV_U]   = ebu_q;
      eb_by_priv[PRIV_S]   = ebs_q;
      eb_by_priv[PRIV_RSV] = 1'b0;
      eb_by_priv[PRIV_M]   = ebm_q;
   end

   assign step_en = step_q;
endmodule

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
   import dbg_halt_pkg::*;
(
   input  logic       resethalt_hit,
   input  logic       halt_hit,
   input  logic       step_hit,
   input  logic       ebreak_hit,
   output entry_req_t req
);
   always_comb begin
      req.valid = resethalt_hit | halt_hit | step_hit | ebreak_hit;
      if (resethalt_hit)   req.cause = CAUSE_RESETHALT;
      else if (halt_hit)   req.cause = CAUSE_HALT;
      else if (step_hit)   req.cause = CAUSE_STEP;
      else if (ebreak_hit) req.cause = CAUSE_EBREAK;
      else                 req.cause = CAUSE_NONE;
   end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
   import dbg_halt_pkg::*;
#(
   parameter int          XLEN         = 64,
   parameter logic [63:0] DBG_ADDR     = 64'h0000_0000_0000_0800,
   parameter logic [63:0] DBG_EXC_ADDR = 64'h0000_0000_0000_0808,
   parameter logic [63:0] RESET_PC     = 64'h0000_0000_8000_0000,
   parameter bit          HAS_SMODE    = 1'b1,
   parameter bit          HAS_UMODE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             halt_req,
   input  logic             resethalt_req,
   input  logic             ebreak_ret,
   input  logic             dret_ret,
   input  logic             exc_ret,
   input  logic             retire,
   input  logic [1:0]       cur_priv,
   input  logic [XLEN-1:0]  save_pc,
   input  logic             cfg_we,
   input  logic [3:0]       cfg_wdata,
   output logic [3:0]       cfg_rdata,
   output logic             dbg_mode,
   output logic             redirect_valid,
   output logic [XLEN-1:0]  redirect_pc,
   output logic             dpc_we,
   output logic [XLEN-1:0]  dpc,
   output logic [2:0]       cause,
   output logic             resume_req,
   output logic [1:0]       resume_priv
);
   localparam logic [XLEN-1:0] ENTRY_PC = DBG_ADDR[XLEN-1:0];
   localparam logic [XLEN-1:0] EXC_PC   = DBG_EXC_ADDR[XLEN-1:0];
   localparam logic [XLEN-1:0] BOOT_PC  = RESET_PC[XLEN-1:0];

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("dbg_halt_ctrl: XLEN must be 32 or 64");
   end
   if (DBG_ADDR[1:0] != 2'b00 || DBG_EXC_ADDR[1:0] != 2'b00) begin : g_bad_align
      $error("dbg_halt_ctrl: debug addresses must be 4-byte aligned");
   end
   if (DBG_ADDR == DBG_EXC_ADDR) begin : g_bad_overlap
      $error("dbg_halt_ctrl: entry and exception addresses must differ");
   end

   logic       halt_rise;
   logic       resethalt_hit;
   logic [3:0] eb_by_priv;
   logic       step_en;
   logic       step_armed;
   logic       halt_hit;
   logic       step_hit;
   logic       ebreak_hit;
   priv_e      saved_priv;
   entry_req_t entry;

   dbg_event_detect u_events (
      .clk           (clk),
      .rst           (rst),
      .halt_req      (halt_req),
      .resethalt_req (resethalt_req),
      .halt_rise     (halt_rise),
      .resethalt_hit (resethalt_hit)
   );

   dbg_cfg_regs #(
      .HAS_SMODE (HAS_SMODE),
      .HAS_UMODE (HAS_UMODE)
   ) u_cfg (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (cfg_we & dbg_mode),
      .wdata      (cfg_wdata),
      .rdata      (cfg_rdata),
      .eb_by_priv (eb_by_priv),
      .step_en    (step_en)
   );

   assign halt_hit   = halt_rise & ~dbg_mode;
   assign step_hit   = retire & step_armed & ~dbg_mode;
   assign ebreak_hit = ebreak_ret & eb_by_priv[cur_priv] & ~dbg_mode;

   dbg_cause_arb u_arb (
      .resethalt_hit (resethalt_hit),
      .halt_hit      (halt_hit),
      .step_hit      (step_hit),
      .ebreak_hit    (ebreak_hit),
      .req           (entry)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dbg_mode       <= 1'b0;
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
         dpc_we         <= 1'b0;
         dpc            <= '0;
         cause          <= CAUSE_NONE;
         resume_req     <= 1'b0;
         resume_priv    <= PRIV_U;
         saved_priv     <= PRIV_U;
         step_armed     <= 1'b0;
      end else begin
         redirect_valid <= 1'b0;
         dpc_we         <= 1'b0;
         resume_req     <= 1'b0;
         if (!dbg_mode) begin
            if (entry.valid) begin
               dbg_mode       <= 1'b1;
               cause          <= entry.cause;
               dpc_we         <= 1'b1;
               redirect_valid <= 1'b1;
               redirect_pc    <= ENTRY_PC;
               step_armed     <= 1'b0;
               if (entry.cause == CAUSE_RESETHALT) begin
                  dpc        <= BOOT_PC;
                  saved_priv <= PRIV_M;
               end else begin
                  dpc        <= save_pc;
                  saved_priv <= priv_e'(cur_priv);
               end
            end
         end else if (exc_ret) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= EXC_PC;
         end else if (dret_ret) begin
            dbg_mode       <= 1'b0;
            resume_req     <= 1'b1;
            redirect_valid <= 1'b1;
            redirect_pc    <= dpc;
            resume_priv    <= saved_priv;
            step_armed     <= step_en;
         end else if (ebreak_ret) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= ENTRY_PC;
         end
      end
   end
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
   parameter int          XLEN         = 64,
   parameter logic [63:0] DBG_ADDR     = 64'h0000_0000_0000_0800,
   parameter logic [63:0] DBG_EXC_ADDR = 64'h0000_0000_0000_0808
) (
   input logic            clk,
   input logic            rst,
   input logic            halt_req,
   input logic            exc_ret,
   input logic            dret_ret,
   input logic            dbg_mode,
   input logic            redirect_valid,
   input logic [XLEN-1:0] redirect_pc,
   input logic            dpc_we,
   input logic [XLEN-1:0] dpc,
   input logic [2:0]      cause,
   input logic            resume_req,
   input logic [3:0]      cfg_rdata
);
   localparam logic [XLEN-1:0] ENTRY_PC = DBG_ADDR[XLEN-1:0];
   localparam logic [XLEN-1:0] EXC_PC   = DBG_EXC_ADDR[XLEN-1:0];

   AST_HALT_EDGE_ENTERS: assert property (@(posedge clk) disable iff (rst)
      (!dbg_mode && $rose(halt_req)) |=> dbg_mode); // R2

   AST_ENTRY_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      $rose(dbg_mode) |-> (dpc_we && redirect_valid && redirect_pc == ENTRY_PC)); // R2

   AST_EXC_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
      (dbg_mode && exc_ret) |=> (dbg_mode && redirect_valid && redirect_pc == EXC_PC && $stable(dpc))); // R5

   AST_DRET_RESUMES: assert property (@(posedge clk) disable iff (rst)
      (dbg_mode && dret_ret && !exc_ret) |=> (!dbg_mode && resume_req && redirect_pc == $past(dpc))); // R6

   AST_RESUME_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      resume_req |-> (!dbg_mode && !dpc_we)); // R6

   AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      dbg_mode |-> (cause == 3'd1 || cause == 3'd3 || cause == 3'd4 || cause == 3'd5)); // R8

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
      !dbg_mode |=> $stable(cfg_rdata)); // R9
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(
   .XLEN         (XLEN),
   .DBG_ADDR     (DBG_ADDR),
   .DBG_EXC_ADDR (DBG_EXC_ADDR)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .halt_req       (halt_req),
   .exc_ret        (exc_ret),
   .dret_ret       (dret_ret),
   .dbg_mode       (dbg_mode),
   .redirect_valid (redirect_valid),
   .redirect_pc    (redirect_pc),
   .dpc_we         (dpc_we),
   .dpc            (dpc),
   .cause          (cause),
   .resume_req     (resume_req),
   .cfg_rdata      (cfg_rdata)
);

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;
   localparam int          XLEN   = 64;
   localparam logic [63:0] A_DBG  = 64'h800;
   localparam logic [63:0] A_EXC  = 64'h808;
   localparam logic [63:0] A_BOOT = 64'h8000_0000;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            halt_req = 1'b0;
   logic            resethalt_req = 1'b0;
   logic            ebreak_ret = 1'b0;
   logic            dret_ret = 1'b0;
   logic            exc_ret = 1'b0;
   logic            retire = 1'b0;
   logic [1:0]      cur_priv = 2'd3;
   logic [XLEN-1:0] save_pc = '0;
   logic            cfg_we = 1'b0;
   logic [3:0]      cfg_wdata = '0;
   logic [3:0]      cfg_rdata;
   logic            dbg_mode;
   logic            redirect_valid;
   logic [XLEN-1:0] redirect_pc;
   logic            dpc_we;
   logic [XLEN-1:0] dpc;
   logic [2:0]      cause;
   logic            resume_req;
   logic [1:0]      resume_priv;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dbg_halt_ctrl #(
      .XLEN (XLEN), .DBG_ADDR (A_DBG), .DBG_EXC_ADDR (A_EXC), .RESET_PC (A_BOOT)
   ) u_dbg_halt_ctrl (
      .clk (clk), .rst (rst), .halt_req (halt_req), .resethalt_req (resethalt_req),
      .ebreak_ret (ebreak_ret), .dret_ret (dret_ret), .exc_ret (exc_ret),
      .retire (retire), .cur_priv (cur_priv), .save_pc (save_pc),
      .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
      .dbg_mode (dbg_mode), .redirect_valid (redirect_valid),
      .redirect_pc (redirect_pc), .dpc_we (dpc_we), .dpc (dpc), .cause (cause),
      .resume_req (resume_req), .resume_priv (resume_priv)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic next_cyc();
      @(negedge clk);
   endtask

   task automatic do_reset(input logic rh, input logic hr_at_release);
      @(negedge clk);
      rst = 1'b1; resethalt_req = rh; halt_req = 1'b0;
      repeat (3) next_cyc();
      rst = 1'b0; halt_req = hr_at_release;
      next_cyc();
      resethalt_req = 1'b0;
   endtask

   task automatic halt_in(input logic [63:0] pc, input logic [1:0] pv);
      halt_req = 1'b0; next_cyc();
      save_pc = pc; cur_priv = pv; halt_req = 1'b1; next_cyc();
      halt_req = 1'b0;
   endtask

   task automatic dret_out();
      dret_ret = 1'b1; next_cyc(); dret_ret = 1'b0;
   endtask

   task automatic cfg_write(input logic [3:0] v);
      cfg_we = 1'b1; cfg_wdata = v; next_cyc(); cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (2) next_cyc();
      chk("R1 dbg_mode in reset", dbg_mode, 0);
      do_reset(1'b0, 1'b0);
      chk("R1 dbg_mode", dbg_mode, 0);
      chk("R1 dpc", dpc, 0);
      chk("R1 cause", cause, 0);
      chk("R1 cfg_rdata", cfg_rdata, 0);
      chk("R1 pulses", {dpc_we, redirect_valid, resume_req}, 0);
      chk("R3 low stays running", dbg_mode, 0);
   endtask

   task automatic t_resethalt();
      do_reset(1'b1, 1'b0);
      chk("R3 dbg_mode", dbg_mode, 1);
      chk("R3 cause", cause, 5);
      chk("R3 dpc", dpc, A_BOOT);
      chk("R3 redirect", {63'd0, redirect_valid} | (redirect_pc << 1), (A_DBG << 1) | 1);
      dret_out();
      chk("R3 resume priv machine", resume_priv, 3);
   endtask

   task automatic t_halt();
      do_reset(1'b0, 1'b0);
      halt_in(64'h1234, 2'd1);
      chk("R2 dbg_mode", dbg_mode, 1);
      chk("R2 cause", cause, 3);
      chk("R2 dpc", dpc, 64'h1234);
      chk("R2 dpc_we", dpc_we, 1);
      chk("R2 redirect_valid", redirect_valid, 1);
      chk("R2 redirect_pc", redirect_pc, A_DBG);
      next_cyc();
      chk("R2 pulses clear", {dpc_we, redirect_valid}, 0);
      save_pc = 64'h5555; halt_req = 1'b1; next_cyc();
      chk("R2 rise while halted ignored", dpc, 64'h1234);
      dret_out();
      next_cyc(); next_cyc();
      chk("R2 held level no retrigger", dbg_mode, 0);
      halt_req = 1'b0;
   endtask

   task automatic t_dret();
      do_reset(1'b0, 1'b0);
      halt_in(64'h1234, 2'd1);
      dret_out();
      chk("R6 dbg_mode cleared", dbg_mode, 0);
      chk("R6 resume_req", resume_req, 1);
      chk("R6 redirect_valid", redirect_valid, 1);
      chk("R6 redirect_pc", redirect_pc, 64'h1234);
      chk("R6 resume_priv", resume_priv, 1);
      dret_out();
      chk("R6 dret while running ignored", {dbg_mode, resume_req, redirect_valid}, 0);
   endtask

   task automatic t_cfg();
      do_reset(1'b0, 1'b0);
      cfg_write(4'hF);
      chk("R9 write while running ignored", cfg_rdata, 0);
      halt_in(64'h40, 2'd3);
      cfg_write(4'h7);
      chk("R9 write while halted", cfg_rdata, 4'h7);
   endtask

   task automatic t_ebreak();
      do_reset(1'b0, 1'b0);
      halt_in(64'h40, 2'd3);
      cfg_write(4'b0001);
      dret_out();
      cur_priv = 2'd0; save_pc = 64'h100; ebreak_ret = 1'b1; next_cyc(); ebreak_ret = 1'b0;
      chk("R4 U ebreak disabled", dbg_mode, 0);
      cur_priv = 2'd1; ebreak_ret = 1'b1; next_cyc(); ebreak_ret = 1'b0;
      chk("R4 S ebreak disabled", dbg_mode, 0);
      cur_priv = 2'd3; save_pc = 64'h104; ebreak_ret = 1'b1; next_cyc(); ebreak_ret = 1'b0;
      chk("R4 M ebreak enters", dbg_mode, 1);
      chk("R4 cause", cause, 1);
      chk("R4 dpc", dpc, 64'h104);
      cfg_write(4'b0100);
      dret_out();
      cur_priv = 2'd3; ebreak_ret = 1'b1; next_cyc(); ebreak_ret = 1'b0;
      chk("R4 M ebreak now disabled", dbg_mode, 0);
      cur_priv = 2'd0; save_pc = 64'h108; ebreak_ret = 1'b1; next_cyc(); ebreak_ret = 1'b0;
      chk("R4 U ebreak enters", {dbg_mode, cause}, {1'b1, 3'd1});
   endtask

   task automatic t_exc();
      do_reset(1'b0, 1'b0);
      exc_ret = 1'b1; next_cyc(); exc_ret = 1'b0;
      chk("R5 exception while running ignored", {dbg_mode, redirect_valid}, 0);
      halt_in(64'h2220, 2'd3);
      next_cyc();
      save_pc = 64'h9999; exc_ret = 1'b1; next_cyc(); exc_ret = 1'b0;
      chk("R5 redirect_valid", redirect_valid, 1);
      chk("R5 redirect_pc", redirect_pc, A_EXC);
      chk("R5 stays halted", dbg_mode, 1);
      chk("R5 dpc kept", dpc, 64'h2220);
      chk("R5 cause kept", cause, 3);
   endtask

   task automatic t_ebreak_dbg();
      do_reset(1'b0, 1'b0);
      halt_in(64'h3330, 2'd3);
      exc_ret = 1'b1; next_cyc(); exc_ret = 1'b0;
      save_pc = 64'h7777; ebreak_ret = 1'b1; next_cyc(); ebreak_ret = 1'b0;
      chk("R10 redirect_valid", redirect_valid, 1);
      chk("R10 redirect_pc", redirect_pc, A_DBG);
      chk("R10 dpc kept", dpc, 64'h3330);
      chk("R10 state kept", {dbg_mode, cause}, {1'b1, 3'd3});
   endtask

   task automatic t_step();
      do_reset(1'b0, 1'b0);
      halt_in(64'h40, 2'd3);
      cfg_write(4'b1000);
      retire = 1'b1; next_cyc(); retire = 1'b0;
      chk("R7 retire while halted ignored", dpc, 64'h40);
      dret_out();
      save_pc = 64'h2000; retire = 1'b1; next_cyc(); retire = 1'b0;
      chk("R7 step enters", dbg_mode, 1);
      chk("R7 cause", cause, 4);
      chk("R7 dpc", dpc, 64'h2000);
      dret_out();
      save_pc = 64'h2004; retire = 1'b1; next_cyc(); retire = 1'b0;
      chk("R7 second step", {dbg_mode, cause}, {1'b1, 3'd4});
      chk("R7 second dpc", dpc, 64'h2004);
      cfg_write(4'b0000);
      dret_out();
      retire = 1'b1; next_cyc(); retire = 1'b0;
      chk("R7 step cleared runs on", dbg_mode, 0);
   endtask

   task automatic t_prio();
      do_reset(1'b1, 1'b1);
      chk("R8 reset-halt beats halt", cause, 5);
      halt_req = 1'b0;
      cfg_write(4'b1001);
      dret_out();
      cur_priv = 2'd3; save_pc = 64'h500;
      halt_req = 1'b1; retire = 1'b1; ebreak_ret = 1'b1; next_cyc();
      halt_req = 1'b0; retire = 1'b0; ebreak_ret = 1'b0;
      chk("R8 halt beats step and ebreak", cause, 3);
      dret_out();
      retire = 1'b1; ebreak_ret = 1'b1; next_cyc();
      retire = 1'b0; ebreak_ret = 1'b0;
      chk("R8 step beats ebreak", cause, 4);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      t_reset();
      t_resethalt();
      t_halt();
      t_dret();
      t_cfg();
      t_ebreak();
      t_exc();
      t_ebreak_dbg();
      t_step();
      t_prio();
      summary();
   end
endmodule